// File: doc/BRIEF.md
# Receive Flow-Control Counter Bank

This block keeps the credit bookkeeping for one channel receiver. Four counters of equal width run side by side. The READY counter counts credits handed to the remote sender. The burst counter counts bursts that have finished. The buffer counter counts receive buffers that the host has supplied. The last-burst counter holds the burst count taken at the most recent disconnect. Three equality flags are derived from these counters. The host reads them through the status word that appears while the link is idle between bursts and between packets.

When a connection ends, READY credits that the departing sender never used are written off. The burst count is loaded into the READY counter, and the same value is stored as the last-burst count. The buffer count is not touched by a disconnect, so the credit the host has granted carries over to the next connection. Only the mode reset or the active-low counter clear returns the counters to zero. The flags are registered one clock behind the counters.

Top module: `fc_counter_bank`

## Requirements
- R1: While `rst` is high at a rising edge, all four counters become 0 and all three flags become 1 at that edge.
- R2: While `ctr_clr_n` is low at a rising edge, all four counters become 0 at that edge. The flags are not forced; they follow the counters one clock later, as for any other change.
- R3: Each edge at which `ready_sent` is high, `disc_evt` is low and no clear is active increments `ready_cnt` by one.
- R4: Each edge at which `burst_end` is high and no clear is active increments `burst_cnt` by one. A disconnect in the same cycle does not stop this increment.
- R5: Each edge at which `buf_grant` is high and no clear is active increments `bufr_cnt` by one. A disconnect leaves `bufr_cnt` unchanged.
- R6: At an edge where `disc_evt` is high and no clear is active, `ready_cnt` and `last_cnt` both take the burst count as it stands after that edge, including any increment at that edge. This load takes priority over `ready_sent`.
- R7: All counters are CNT_W bits wide (16 by default) and wrap from all-ones to zero.
- R8: `all_bursts_flag` equals 1 exactly when `ready_cnt` equalled `burst_cnt` over the full width one clock earlier.
- R9: `bufs_reached_flag` equals 1 exactly when `last_cnt` equalled `bufr_cnt` one clock earlier.
- R10: `all_readies_flag` equals 1 exactly when `ready_cnt` equalled `bufr_cnt` one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high mode reset |
| ctr_clr_n | input | 1 | Synchronous active-low clear of the four counters |
| ready_sent | input | 1 | One READY credit was issued this cycle |
| burst_end | input | 1 | One burst completed this cycle |
| buf_grant | input | 1 | Host added one receive buffer this cycle |
| disc_evt | input | 1 | Connection ended this cycle |
| ready_cnt | output | CNT_W | READY counter |
| burst_cnt | output | CNT_W | Completed-burst counter |
| bufr_cnt | output | CNT_W | Available-buffer counter |
| last_cnt | output | CNT_W | Burst count captured at the last disconnect |
| all_bursts_flag | output | 1 | READY count equals burst count |
| bufs_reached_flag | output | 1 | Last-burst count equals buffer count |
| all_readies_flag | output | 1 | READY count equals buffer count |

## Verification
A strobe applied before a rising edge changes the counters at that edge, so the bench drives on the falling edge and compares counters at the next falling edge. The flags come one register further on. The bench model therefore computes each expected flag from the counter values it held before the same edge, so a flag check lags the counter change it reflects by one clock. Disconnects that coincide with a READY or a burst, both clear paths, and a full wrap of the buffer counter are directed cases on top of the vector table.

// File: rtl/fc_pkg.sv
package fc_pkg;
  localparam int CNT_W_DEF = 16;
  localparam int NUM_FLAGS = 3;

  typedef enum int {
    FL_ALL_READIES  = 0,
    FL_BUFS_REACHED = 1,
    FL_ALL_BURSTS   = 2
  } flag_idx_e;
endpackage

// File: rtl/fc_ctr.sv
module fc_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         inc,
  output logic [W-1:0] q
);
  // priority: clear, then load, then increment
  always_ff @(posedge clk) begin
    if (clr)
      q <= '0;
    else if (load)
      q <= load_val;
    else if (inc)
      q <= q + W'(1);
  end

  assert_clear_zero_R2: assert property (@(posedge clk) clr |=> (q == '0))
    else $error("counter not zero after clear");

  assert_step_one_R7: assert property (@(posedge clk) disable iff (clr)
    (!load && inc) |=> (q == $past(q) + W'(1)))
    else $error("counter step not modulo +1");
endmodule

// File: rtl/fc_flags.sv
module fc_flags #(
  parameter int W = 16,
  parameter int N = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N-1:0][W-1:0] a_vec,
  input  logic [N-1:0][W-1:0] b_vec,
  output logic [N-1:0]        flag
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    always_ff @(posedge clk) begin
      if (rst)
        flag[i] <= 1'b1;
      else
        flag[i] <= (a_vec[i] == b_vec[i]);
    end
  end
endmodule

// File: rtl/fc_counter_bank.sv
module fc_counter_bank
  import fc_pkg::*;
#(
  parameter int CNT_W = CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctr_clr_n,
  input  logic             ready_sent,
  input  logic             burst_end,
  input  logic             buf_grant,
  input  logic             disc_evt,
  output logic [CNT_W-1:0] ready_cnt,
  output logic [CNT_W-1:0] burst_cnt,
  output logic [CNT_W-1:0] bufr_cnt,
  output logic [CNT_W-1:0] last_cnt,
  output logic             all_bursts_flag,
  output logic             bufs_reached_flag,
  output logic             all_readies_flag
);
  logic                         clr;
  logic [CNT_W-1:0]             burst_nxt;
  logic [NUM_FLAGS-1:0][CNT_W-1:0] cmp_a, cmp_b;
  logic [NUM_FLAGS-1:0]         flags;

  assign clr       = rst | ~ctr_clr_n;
  // burst count as it will stand after this edge, used for write-off
  assign burst_nxt = burst_cnt + CNT_W'(burst_end);

  fc_ctr #(.W(CNT_W)) u_burst (
    .clk(clk), .clr(clr), .load(1'b0), .load_val('0),
    .inc(burst_end), .q(burst_cnt));

  fc_ctr #(.W(CNT_W)) u_ready (
    .clk(clk), .clr(clr), .load(disc_evt), .load_val(burst_nxt),
    .inc(ready_sent), .q(ready_cnt));

  fc_ctr #(.W(CNT_W)) u_bufr (
    .clk(clk), .clr(clr), .load(1'b0), .load_val('0),
    .inc(buf_grant), .q(bufr_cnt));

  fc_ctr #(.W(CNT_W)) u_last (
    .clk(clk), .clr(clr), .load(disc_evt), .load_val(burst_nxt),
    .inc(1'b0), .q(last_cnt));

  always_comb begin
    cmp_a = '0;
    cmp_b = '0;
    cmp_a[FL_ALL_BURSTS]   = ready_cnt;  cmp_b[FL_ALL_BURSTS]   = burst_cnt;
    cmp_a[FL_BUFS_REACHED] = last_cnt;   cmp_b[FL_BUFS_REACHED] = bufr_cnt;
    cmp_a[FL_ALL_READIES]  = ready_cnt;  cmp_b[FL_ALL_READIES]  = bufr_cnt;
  end

  fc_flags #(.W(CNT_W), .N(NUM_FLAGS)) u_flags (
    .clk(clk), .rst(rst), .a_vec(cmp_a), .b_vec(cmp_b), .flag(flags));

  assign all_bursts_flag   = flags[FL_ALL_BURSTS];
  assign bufs_reached_flag = flags[FL_BUFS_REACHED];
  assign all_readies_flag  = flags[FL_ALL_READIES];

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (ready_cnt == '0 && burst_cnt == '0 && bufr_cnt == '0 &&
             last_cnt == '0 && all_bursts_flag && bufs_reached_flag && all_readies_flag))
    else $error("reset state wrong");

  assert_ready_inc_R3: assert property (@(posedge clk) disable iff (clr)
    (ready_sent && !disc_evt) |=> (ready_cnt == $past(ready_cnt) + CNT_W'(1)))
    else $error("ready counter did not step");

  assert_burst_inc_R4: assert property (@(posedge clk) disable iff (clr)
    burst_end |=> (burst_cnt == $past(burst_cnt) + CNT_W'(1)))
    else $error("burst counter did not step");

  assert_buf_keep_R5: assert property (@(posedge clk) disable iff (clr)
    (disc_evt && !buf_grant) |=> $stable(bufr_cnt))
    else $error("buffer credit lost at disconnect");

  assert_writeoff_R6: assert property (@(posedge clk) disable iff (clr)
    disc_evt |=> (ready_cnt == burst_cnt && last_cnt == burst_cnt))
    else $error("write-off did not align counters");

  assert_flag_ab_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (all_bursts_flag == $past(ready_cnt == burst_cnt)))
    else $error("all-bursts flag wrong");

  assert_flag_br_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (bufs_reached_flag == $past(last_cnt == bufr_cnt)))
    else $error("buffers-reached flag wrong");

  assert_flag_ar_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (all_readies_flag == $past(ready_cnt == bufr_cnt)))
    else $error("all-readies flag wrong");
endmodule

// File: tb/fc_counter_bank_tb.sv
module fc_counter_bank_tb;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst, ctr_clr_n, ready_sent, burst_end, buf_grant, disc_evt;
  logic [W-1:0] ready_cnt, burst_cnt, bufr_cnt, last_cnt;
  logic all_bursts_flag, bufs_reached_flag, all_readies_flag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit do_chk = 1'b1;

  logic [W-1:0] m_rdy, m_bst, m_buf, m_last;
  logic m_fab, m_fbr, m_far;

  always #4 clk = ~clk;

  fc_counter_bank #(.CNT_W(W)) u_dut (
    .clk(clk), .rst(rst), .ctr_clr_n(ctr_clr_n),
    .ready_sent(ready_sent), .burst_end(burst_end),
    .buf_grant(buf_grant), .disc_evt(disc_evt),
    .ready_cnt(ready_cnt), .burst_cnt(burst_cnt),
    .bufr_cnt(bufr_cnt), .last_cnt(last_cnt),
    .all_bursts_flag(all_bursts_flag),
    .bufs_reached_flag(bufs_reached_flag),
    .all_readies_flag(all_readies_flag));

  // stimulus bits: {ctr_clr_n, disc_evt, buf_grant, burst_end, ready_sent}
  localparam int NV = 20;
  localparam logic [4:0] VEC [0:NV-1] = '{
    5'b10001, 5'b10001, 5'b10001, 5'b10100, 5'b10100,
    5'b10010, 5'b10011, 5'b10000, 5'b11001, 5'b10101,
    5'b10111, 5'b11010, 5'b10001, 5'b10001, 5'b11011,
    5'b10100, 5'b00111, 5'b10010, 5'b11100, 5'b10001
  };

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R3 R6 ready_cnt", ready_cnt, m_rdy);
    chk("R4 R7 burst_cnt", burst_cnt, m_bst);
    chk("R5 R7 bufr_cnt", bufr_cnt, m_buf);
    chk("R6 last_cnt", last_cnt, m_last);
    chk("R8 all_bursts_flag", W'(all_bursts_flag), W'(m_fab));
    chk("R9 bufs_reached_flag", W'(bufs_reached_flag), W'(m_fbr));
    chk("R10 all_readies_flag", W'(all_readies_flag), W'(m_far));
  endtask

  // one clock: drive at falling edge, model the rising edge, check at next falling edge
  task automatic cyc(input logic r, input logic [4:0] v);
    logic [W-1:0] bn;
    logic nab, nbr, nar;
    rst = r; ctr_clr_n = v[4]; disc_evt = v[3];
    buf_grant = v[2]; burst_end = v[1]; ready_sent = v[0];
    @(posedge clk);
    nab = (m_rdy == m_bst); nbr = (m_last == m_buf); nar = (m_rdy == m_buf);
    if (r) begin
      m_rdy = '0; m_bst = '0; m_buf = '0; m_last = '0;
      m_fab = 1'b1; m_fbr = 1'b1; m_far = 1'b1;
    end else begin
      m_fab = nab; m_fbr = nbr; m_far = nar;
      if (!v[4]) begin
        m_rdy = '0; m_bst = '0; m_buf = '0; m_last = '0;
      end else begin
        bn = m_bst + W'(v[1]);
        m_buf = m_buf + W'(v[2]);
        if (v[3]) begin
          m_rdy = bn; m_last = bn;
        end else begin
          m_rdy = m_rdy + W'(v[0]);
        end
        m_bst = bn;
      end
    end
    @(negedge clk);
    if (do_chk) check_all();
  endtask

  initial begin
    m_rdy = 'x; m_bst = 'x; m_buf = 'x; m_last = 'x;
    m_fab = 1'bx; m_fbr = 1'bx; m_far = 1'bx;
    @(negedge clk);
    // R1: reset state
    for (int i = 0; i < 3; i++) cyc(1'b1, 5'b11111);
    // table walk covering R3 R4 R5 R6 R2 and flags R8 R9 R10
    for (int i = 0; i < NV; i++) cyc(1'b0, VEC[i]);
    // R6: disconnect with ready and burst together; copy wins
    cyc(1'b0, 5'b10001);
    cyc(1'b0, 5'b11011);
    chk("R6 copy beats ready", ready_cnt, burst_cnt);
    // R5: buffer credit survives a disconnect
    cyc(1'b0, 5'b10100);
    cyc(1'b0, 5'b11000);
    chk("R5 buffer kept", bufr_cnt, m_buf);
    cyc(1'b0, 5'b10000);
    // R2: counter clear then flags one clock later
    cyc(1'b0, 5'b00000);
    chk("R2 cleared burst", burst_cnt, '0);
    cyc(1'b0, 5'b10000);
    chk("R2 flags after clear", W'(all_readies_flag), W'(1));
    // R7: wrap the buffer counter through all-ones
    do_chk = 1'b0;
    for (int i = 0; i < 65535; i++) cyc(1'b0, 5'b10100);
    do_chk = 1'b1;
    chk("R7 at all-ones", bufr_cnt, 16'hFFFF);
    cyc(1'b0, 5'b10100);
    chk("R7 wrapped to zero", bufr_cnt, 16'h0000);
    cyc(1'b0, 5'b10000);
    // R1: mode reset mid-run
    cyc(1'b0, 5'b10111);
    cyc(1'b1, 5'b10111);
    chk("R1 reset mid-run", ready_cnt | burst_cnt | bufr_cnt | last_cnt, '0);
    cyc(1'b0, 5'b10000);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule